// File: doc/BRIEF.md
# Dual-FIFO Loopback Steering Controller

This block steers traffic between a wide bidirectional data port and two FIFOs: an inbound FIFO (called F1 here) that the port can fill, and an outbound FIFO (F2). In normal operation the port either writes bus words into F1 or reads F1 onto the bus, depending on a direction control. When loopback is selected, the controller pulls words out of F2 and writes them straight back into F1. Whether each looped word is also driven onto the port depends on the port direction.

The controller watches the F1 full flag and the F2 empty flag. From them it produces the F2 read enable, the F1 write enable and read enable, the port output enable and the F1 write-data selection. The mode, direction and transfer controls are registered on the port clock. The F1 write enable is gated by the F1 full flag in the same cycle, with no register in between.

When F1 fills during a loop, F2 keeps being drained onto the port if the port is reading, and stops otherwise. When F2 runs dry during a loop, the last word it produced is written into F1 again on every cycle until F1 fills or loopback is switched off.

Top module: `loopback_ctrl`

## Requirements
- R1: While `rst_n` is low, `f1_wen`, `f1_ren`, `f2_ren` and `bus_oe` are all low.
- R2: `loop_sel`, `dir_rd` and `xfer` take effect one clock edge after they are sampled. A change on them between edges leaves the outputs unchanged until the next rising edge.
- R3: In loopback, `f2_ren` is high exactly when F2 is not empty and either F1 is not full or the port reads (`dir_rd`=1). `f2_ren` is never high while `f2_empty` is high.
- R4: In loopback, `f1_wdata` equals `f2_rdata`. `f1_wen` rises in the cycle after the first F2 read of the loop and not before.
- R5: In loopback with the port writing (`dir_rd`=0), `bus_oe` is low.
- R6: In loopback with the port reading (`dir_rd`=1), `bus_oe` is high and `bus_out` equals `f2_rdata`.
- R7: In loopback with F1 full, F2 reads continue only if the port reads. Each word read then appears on `bus_out` with `f1_wen` low.
- R8: After F2 empties during loopback, `f1_wen` stays high with the last F2 word on `f1_wdata`, on every cycle while F1 is not full.
- R9: Outside loopback with the port writing, a registered `xfer` gives `f1_wen`=1 (unless F1 is full). `f1_wdata` is then the `bus_in` word sampled on the same edge as `xfer`.
- R10: Outside loopback with the port reading, `bus_oe`=1 and `bus_out`=`f1_rdata`. `f1_ren` equals registered `xfer` and not `f1_empty`. `f2_ren` stays low.
- R11: `f1_wen` is low in any cycle in which `f1_full` is high, including the cycle in which the flag first rises.
- R12: Switching loopback off clears the held F2 word. When loopback is turned on again with F2 empty, `f1_wen` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| loop_sel | input | 1 | Loopback select |
| dir_rd | input | 1 | Port direction: 1 = port reads, 0 = port writes |
| xfer | input | 1 | Normal-mode transfer request on the port |
| bus_in | input | W | Data arriving from the port pins |
| bus_out | output | W | Data driven toward the port pins |
| bus_oe | output | 1 | Port output enable |
| f1_full | input | 1 | F1 full flag |
| f1_empty | input | 1 | F1 empty flag |
| f1_rdata | input | W | F1 output word |
| f1_wen | output | 1 | F1 write enable |
| f1_ren | output | 1 | F1 read enable |
| f1_wdata | output | W | F1 write data |
| f2_empty | input | 1 | F2 empty flag |
| f2_rdata | input | W | F2 output word (updated on the edge that reads) |
| f2_ren | output | 1 | F2 read enable |

## Verification
The bench drains a short burst out of F2 past its last word and counts the F1 writes that follow. A design that drops the held word stops writing early. A design that re-reads an empty F2 corrupts the word count. The bench raises F1 full mid-loop in both directions: a design that stalls F2 while the port reads loses port data, and one that keeps reading while the port writes discards words. It also raises full between edges, which catches a write enable computed from a registered copy of the flag. Finally it turns loopback off and on again with F2 empty, which exposes a stale held word that is written a second time.

// File: rtl/loopback_ctrl_pkg.sv
package loopback_ctrl_pkg;

  // Registered port controls
  typedef struct packed {
    logic loop;
    logic rd;
    logic xfer;
  } lbc_ctl_t;

  localparam int unsigned LBC_CTL_W = $bits(lbc_ctl_t);

endpackage

// File: rtl/lbc_ctl_reg.sv
module lbc_ctl_reg
  import loopback_ctrl_pkg::*;
#(
  parameter int unsigned W = 36
) (
  input  logic           clk,
  input  logic           rst_n,
  input  lbc_ctl_t       ctl_d,
  input  logic [W-1:0]   bus_d,
  output lbc_ctl_t       ctl_q,
  output logic [W-1:0]   bus_q
);

  lbc_ctl_t     ctl_nxt;
  logic [W-1:0] bus_nxt;
  logic         bus_ce;

  // bus word is only captured for a normal-mode write request
  always_comb begin
    ctl_nxt = ctl_d;
    bus_ce  = ctl_d.xfer & ~ctl_d.rd & ~ctl_d.loop;
    bus_nxt = bus_ce ? bus_d : bus_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
      bus_q <= '0;
    end else begin
      ctl_q <= ctl_nxt;
      bus_q <= bus_nxt;
    end
  end

endmodule

// File: rtl/lbc_loop_seq.sv
module lbc_loop_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic loop_q,
  input  logic rd_q,
  input  logic f1_full,
  input  logic f2_empty,
  output logic f2_ren,
  output logic have_word
);

  logic have_nxt;

  // drain F2 while a destination exists: F1 space, or a reading port
  always_comb begin
    f2_ren = loop_q & ~f2_empty & (~f1_full | rd_q);
  end

  always_comb begin
    if (!loop_q) begin
      have_nxt = 1'b0;
    end else if (f2_ren) begin
      have_nxt = 1'b1;
    end else begin
      have_nxt = have_word;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_word <= 1'b0;
    end else begin
      have_word <= have_nxt;
    end
  end

endmodule

// File: rtl/lbc_wr_path.sv
module lbc_wr_path #(
  parameter int unsigned W = 36
) (
  input  logic         loop_q,
  input  logic         rd_q,
  input  logic         xfer_q,
  input  logic [W-1:0] bus_q,
  input  logic         have_word,
  input  logic         f1_full,
  input  logic         f1_empty,
  input  logic [W-1:0] f2_rdata,
  output logic         f1_wen,
  output logic         f1_ren,
  output logic [W-1:0] f1_wdata
);

  logic wen_raw;

  always_comb begin
    if (loop_q) begin
      wen_raw  = have_word;
      f1_wdata = f2_rdata;
      f1_ren   = 1'b0;
    end else begin
      wen_raw  = xfer_q & ~rd_q;
      f1_wdata = bus_q;
      f1_ren   = xfer_q & rd_q & ~f1_empty;
    end
    // same-cycle gating by the live full flag
    f1_wen = wen_raw & ~f1_full;
  end

endmodule

// File: rtl/lbc_port_drv.sv
module lbc_port_drv #(
  parameter int unsigned W = 36
) (
  input  logic         loop_q,
  input  logic         rd_q,
  input  logic [W-1:0] f1_rdata,
  input  logic [W-1:0] f2_rdata,
  output logic [W-1:0] bus_out,
  output logic         bus_oe
);

  always_comb begin
    bus_oe = rd_q;
    if (!rd_q) begin
      bus_out = '0;
    end else if (loop_q) begin
      bus_out = f2_rdata;
    end else begin
      bus_out = f1_rdata;
    end
  end

endmodule

// File: rtl/loopback_ctrl.sv
module loopback_ctrl
  import loopback_ctrl_pkg::*;
#(
  parameter int unsigned W = 36
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         loop_sel,
  input  logic         dir_rd,
  input  logic         xfer,
  input  logic [W-1:0] bus_in,
  output logic [W-1:0] bus_out,
  output logic         bus_oe,
  input  logic         f1_full,
  input  logic         f1_empty,
  input  logic [W-1:0] f1_rdata,
  output logic         f1_wen,
  output logic         f1_ren,
  output logic [W-1:0] f1_wdata,
  input  logic         f2_empty,
  input  logic [W-1:0] f2_rdata,
  output logic         f2_ren
);

  lbc_ctl_t     ctl_d;
  lbc_ctl_t     ctl_q;
  logic [W-1:0] bus_q;
  logic         have_word;

  always_comb begin
    ctl_d.loop = loop_sel;
    ctl_d.rd   = dir_rd;
    ctl_d.xfer = xfer;
  end

  lbc_ctl_reg #(.W(W)) ctl_reg_i (
    .clk   (clk),
    .rst_n (rst_n),
    .ctl_d (ctl_d),
    .bus_d (bus_in),
    .ctl_q (ctl_q),
    .bus_q (bus_q)
  );

  lbc_loop_seq loop_seq_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .loop_q    (ctl_q.loop),
    .rd_q      (ctl_q.rd),
    .f1_full   (f1_full),
    .f2_empty  (f2_empty),
    .f2_ren    (f2_ren),
    .have_word (have_word)
  );

  lbc_wr_path #(.W(W)) wr_path_i (
    .loop_q    (ctl_q.loop),
    .rd_q      (ctl_q.rd),
    .xfer_q    (ctl_q.xfer),
    .bus_q     (bus_q),
    .have_word (have_word),
    .f1_full   (f1_full),
    .f1_empty  (f1_empty),
    .f2_rdata  (f2_rdata),
    .f1_wen    (f1_wen),
    .f1_ren    (f1_ren),
    .f1_wdata  (f1_wdata)
  );

  lbc_port_drv #(.W(W)) port_drv_i (
    .loop_q   (ctl_q.loop),
    .rd_q     (ctl_q.rd),
    .f1_rdata (f1_rdata),
    .f2_rdata (f2_rdata),
    .bus_out  (bus_out),
    .bus_oe   (bus_oe)
  );

endmodule

// File: rtl/loopback_ctrl_chk.sv
module loopback_ctrl_chk #(
  parameter int unsigned W = 36
) (
  input logic         clk,
  input logic         rst_n,
  input logic         loop_q,
  input logic         rd_q,
  input logic         f1_full,
  input logic         f2_empty,
  input logic [W-1:0] f2_rdata,
  input logic [W-1:0] f1_wdata,
  input logic [W-1:0] bus_out,
  input logic         bus_oe,
  input logic         f1_wen,
  input logic         f1_ren,
  input logic         f2_ren
);

  // R1
  rst_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> (!f1_wen && !f1_ren && !f2_ren && !bus_oe));

  // R3
  no_empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    f2_empty |-> !f2_ren);

  // R4
  loop_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_q && f1_wen) |-> (f1_wdata == f2_rdata));

  // R5
  loop_wr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_q && !rd_q) |-> !bus_oe);

  // R6
  loop_rd_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_q && rd_q) |-> (bus_oe && bus_out == f2_rdata));

  // R7
  full_wr_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_q && !rd_q && f1_full) |-> !f2_ren);

  // R8
  hold_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_q && !f1_full && $past(f2_ren)) |-> f1_wen);

  // R10
  normal_no_f2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !loop_q |-> !f2_ren);

  // R11
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    f1_full |-> !f1_wen);

endmodule

bind loopback_ctrl loopback_ctrl_chk #(.W(W)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .loop_q   (ctl_q.loop),
  .rd_q     (ctl_q.rd),
  .f1_full  (f1_full),
  .f2_empty (f2_empty),
  .f2_rdata (f2_rdata),
  .f1_wdata (f1_wdata),
  .bus_out  (bus_out),
  .bus_oe   (bus_oe),
  .f1_wen   (f1_wen),
  .f1_ren   (f1_ren),
  .f2_ren   (f2_ren)
);

// File: tb/loopback_ctrl_tb.sv
module loopback_ctrl_tb_top;

  localparam int unsigned W = 36;
  localparam logic [W-1:0] F1_WORD = 36'h7_1357_9BDF;
  localparam logic [W-1:0] BASE_A  = 36'h9_0000_0100;
  localparam logic [W-1:0] BASE_B  = 36'h5_0000_0200;

  // {rd, xfer, full, f1_empty, tag[7:0], exp_wen, exp_ren, exp_oe}
  localparam int NV = 8;
  localparam logic [14:0] VEC [NV] = '{
    {1'b0, 1'b1, 1'b0, 1'b0, 8'h11, 3'b100},
    {1'b0, 1'b1, 1'b1, 1'b0, 8'h22, 3'b000},
    {1'b0, 1'b0, 1'b0, 1'b0, 8'h33, 3'b000},
    {1'b1, 1'b1, 1'b0, 1'b0, 8'h44, 3'b011},
    {1'b1, 1'b1, 1'b0, 1'b1, 8'h55, 3'b001},
    {1'b1, 1'b0, 1'b0, 1'b0, 8'h66, 3'b001},
    {1'b0, 1'b1, 1'b0, 1'b0, 8'h5A, 3'b100},
    {1'b1, 1'b1, 1'b1, 1'b0, 8'h77, 3'b011}
  };

  logic         clk = 1'b0;
  logic         rst_n;
  logic         loop_sel, dir_rd, xfer;
  logic [W-1:0] bus_in, bus_out, f1_rdata, f1_wdata, f2_rdata;
  logic         bus_oe, f1_full, f1_empty, f1_wen, f1_ren, f2_empty, f2_ren;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  loopback_ctrl #(.W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .loop_sel(loop_sel), .dir_rd(dir_rd), .xfer(xfer),
    .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe),
    .f1_full(f1_full), .f1_empty(f1_empty), .f1_rdata(f1_rdata),
    .f1_wen(f1_wen), .f1_ren(f1_ren), .f1_wdata(f1_wdata),
    .f2_empty(f2_empty), .f2_rdata(f2_rdata), .f2_ren(f2_ren)
  );

  // F2 stub: synchronous read, output word changes on the reading edge
  logic         f2_load;
  int           f2_n;
  logic [W-1:0] f2_base;
  int           f2_cnt;
  int           f2_idx;
  always @(posedge clk) begin
    if (f2_load) begin
      f2_cnt <= f2_n;
      f2_idx <= 0;
    end else if (f2_ren === 1'b1 && f2_cnt != 0) begin
      f2_rdata <= f2_base + W'(f2_idx);
      f2_idx   <= f2_idx + 1;
      f2_cnt   <= f2_cnt - 1;
    end
  end
  assign f2_empty = (f2_cnt == 0);

  // F1 stub: counts accepted writes
  int           wr_cnt = 0;
  logic [W-1:0] last_wr;
  always @(posedge clk) begin
    if (f1_wen === 1'b1) begin
      wr_cnt  <= wr_cnt + 1;
      last_wr <= f1_wdata;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic after_edge();
    @(posedge clk);
    #1;
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int c0;
    rst_n = 1'b0; loop_sel = 1'b0; dir_rd = 1'b0; xfer = 1'b0;
    bus_in = '0; f1_full = 1'b0; f1_empty = 1'b0; f1_rdata = F1_WORD;
    f2_load = 1'b1; f2_n = 0; f2_base = '0; f2_rdata = '0;
    // drive controls active during reset: outputs must stay quiet
    loop_sel = 1'b1; dir_rd = 1'b1; xfer = 1'b1;
    after_edge();
    after_edge();
    chk({f1_wen, f1_ren, f2_ren, bus_oe} == 4'b0, "R1 reset quiet",
        {f1_wen, f1_ren, f2_ren, bus_oe}, 0);
    @(negedge clk);
    loop_sel = 1'b0; dir_rd = 1'b0; xfer = 1'b0; f2_load = 1'b0;
    rst_n = 1'b1;

    // normal-mode vector table (R9 R10 R11)
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      dir_rd   = VEC[i][14];
      xfer     = VEC[i][13];
      f1_full  = VEC[i][12];
      f1_empty = VEC[i][11];
      bus_in   = {4'hA, {4{VEC[i][10:3]}}};
      after_edge();
      chk({f1_wen, f1_ren, bus_oe} == VEC[i][2:0], "R9/R10/R11 enables",
          {f1_wen, f1_ren, bus_oe}, VEC[i][2:0]);
      if (VEC[i][2])
        chk(f1_wdata == {4'hA, {4{VEC[i][10:3]}}}, "R9 write data", f1_wdata,
            {4'hA, {4{VEC[i][10:3]}}});
      if (VEC[i][0])
        chk(bus_out == F1_WORD && f2_ren == 1'b0, "R10 read drive", bus_out, F1_WORD);
    end

    // R2: input change between edges has no effect until next edge
    @(negedge clk);
    dir_rd = 1'b0; xfer = 1'b1; f1_full = 1'b0;
    after_edge();
    @(negedge clk);
    xfer = 1'b0;
    #1;
    chk(f1_wen == 1'b1, "R2 held until edge", f1_wen, 1);
    after_edge();
    chk(f1_wen == 1'b0, "R2 taken at edge", f1_wen, 0);

    // Loopback, port reading, F2 holds three words
    @(negedge clk);
    f2_base = BASE_A; f2_n = 3; f2_load = 1'b1;
    loop_sel = 1'b1; dir_rd = 1'b1;
    after_edge();                       // P1
    chk(f2_ren == 1'b1, "R3 read starts", f2_ren, 1);
    chk(f1_wen == 1'b0, "R4 no write before first read", f1_wen, 0);
    @(negedge clk);
    f2_load = 1'b0;
    after_edge();                       // P2
    c0 = wr_cnt;
    chk(f1_wen == 1'b1 && f1_wdata == BASE_A, "R4 first looped word", f1_wdata, BASE_A);
    chk(bus_oe == 1'b1 && bus_out == BASE_A, "R6 looped word on port", bus_out, BASE_A);
    after_edge();                       // P3
    after_edge();                       // P4
    chk(f2_ren == 1'b0, "R3 stop on empty", f2_ren, 0);
    chk(f1_wen == 1'b1 && f1_wdata == BASE_A + 2, "R8 last word held", f1_wdata, BASE_A + 2);
    after_edge();                       // P5
    after_edge();                       // P6
    after_edge();                       // P7
    chk(wr_cnt - c0 == 5, "R8 repeat writes", wr_cnt - c0, 5);
    chk(last_wr == BASE_A + 2, "R8 repeated word", last_wr, BASE_A + 2);
    @(negedge clk);
    f1_full = 1'b1;
    #1;
    chk(f1_wen == 1'b0, "R11 full gates same cycle", f1_wen, 0);

    // F1 full, port writing: F2 must not be read
    @(negedge clk);
    dir_rd = 1'b0; f2_base = BASE_B; f2_n = 2; f2_load = 1'b1;
    after_edge();
    chk(f2_ren == 1'b0, "R7 no read when full and writing", f2_ren, 0);
    chk(bus_oe == 1'b0, "R5 port quiet in loop write", bus_oe, 0);
    @(negedge clk);
    f2_load = 1'b0; dir_rd = 1'b1;
    after_edge();
    chk(f2_ren == 1'b1, "R7 read resumes for port", f2_ren, 1);
    after_edge();
    chk(bus_out == BASE_B && bus_oe == 1'b1 && f1_wen == 1'b0, "R7 word only to port",
        bus_out, BASE_B);

    // F1 has space, port writing: writes continue, port undriven
    @(negedge clk);
    f1_full = 1'b0; dir_rd = 1'b0;
    after_edge();
    chk(bus_oe == 1'b0 && f1_wen == 1'b1, "R5 loop write quiet", {bus_oe, f1_wen}, 2'b01);

    // Loopback off, then on again with F2 empty
    @(negedge clk);
    loop_sel = 1'b0;
    after_edge();
    chk(f1_wen == 1'b0 && f2_ren == 1'b0, "R12 off stops loop", {f1_wen, f2_ren}, 0);
    @(negedge clk);
    loop_sel = 1'b1;
    after_edge();
    chk(f2_empty == 1'b1 && f1_wen == 1'b0, "R12 no stale word", f1_wen, 0);
    after_edge();
    chk(f1_wen == 1'b0, "R12 still no stale word", f1_wen, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule